// File: doc/BRIEF.md
# Microcontroller ALU with Carry Chaining and Coded Compare

This block is the arithmetic and logic unit for a small command-processing microcontroller. On each cycle it takes a 5-bit operation code and two 32-bit operands and produces a 32-bit result combinationally. One 32-bit carry register holds state between operations. Only the plain add and the plain subtract write it. The add-high and subtract-high operations read it, so a wide sum or difference can be built one 32-bit word at a time, starting with the lowest word.

Besides the carry pair, the unit performs bitwise logic, three shift kinds, a left rotate, an 8-by-8 multiply, unsigned minimum and maximum, and bit-clear. It also has a three-way unsigned compare that returns one of three fixed code values, a highest-set-bit index, and a packed single-bit write. The packed write takes both the bit value and the bit position from the second operand. An operation code outside the supported set raises an illegal flag, forces the result to zero and leaves the carry untouched. The register file, immediate handling and instruction decode belong to the surrounding core.

Top module: `mcu_alu`

## Requirements
- R1: Opcode 0 (add) returns (a + b) mod 2^32. On the next rising clock edge the carry register becomes 1 if the unsigned sum exceeded 2^32-1, and 0 otherwise.
- R2: Opcode 1 (add-high) returns (a + b + carry) mod 2^32 and leaves the carry register unchanged.
- R3: Opcode 2 (subtract) returns (a - b) mod 2^32. On the next rising edge the carry register becomes 0xFFFFFFFF when a < b unsigned, and 0 otherwise.
- R4: Opcode 3 (subtract-high) returns (a - b + carry) mod 2^32 and leaves the carry register unchanged.
- R5: Logic operations: opcode 4 returns a AND b, 5 returns a OR b, 6 returns a XOR b, 7 returns NOT a, and 16 returns a AND NOT b (bit-clear).
- R6: Opcode 8 shifts left, 9 shifts right logically, 10 shifts right arithmetically (sign-filled) and 11 rotates left. Each shifts or rotates a by b[4:0] only, and the upper bits of b are ignored.
- R7: Opcode 12 returns the unsigned product a[7:0] * b[7:0], zero-extended to 32 bits.
- R8: Opcode 13 returns the unsigned minimum of a and b, and opcode 14 returns the unsigned maximum.
- R9: Opcode 15 compares a and b as unsigned numbers. It returns 0x00 when a > b, 0x2B when a == b and 0x1E when a < b.
- R10: Opcode 17 returns 0 when b is zero. Otherwise it returns the index (0 to 31) of the highest set bit of b.
- R11: Opcode 18 returns a with bit number b[5:1] replaced by b[0], and all other bits of a kept.
- R12: Opcodes 19 to 31 drive illegal high, return 0 and leave the carry register unchanged. Opcodes 0 to 18 drive illegal low.
- R13: While reset is asserted (active low) the carry register reads 0. The carry output always shows the register. Opcodes other than 0 and 2 never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the carry register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the carry |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (shift amount, bit selector, or packed bit write) |
| result_o | output | 32 | Combinational result of the current operation |
| carry_o | output | 32 | Current content of the carry register |
| illegal_o | output | 1 | High while op_i is not a supported operation code |

## Verification
Random operands over all 32 operation codes are checked against a reference model. That model tracks its own copy of the carry, so the illegal codes and every operation that must keep the carry are covered too. Directed two-word chains separate a carry of 1 after an add overflow from an all-ones borrow after a subtract underflow, and show how each feeds the high-word step that follows. Operand pairs that are equal, or that differ only in the low byte, probe the three compare codes and the minimum/maximum tie. Shift amounts with set upper bits, sign-set operands and a zero second operand test the masking of the shift amount, the sign fill and the zero case of the highest-set-bit index.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 5'd0,
        OP_ADDHI  = 5'd1,
        OP_SUB    = 5'd2,
        OP_SUBHI  = 5'd3,
        OP_AND    = 5'd4,
        OP_OR     = 5'd5,
        OP_XOR    = 5'd6,
        OP_NOT    = 5'd7,
        OP_SHL    = 5'd8,
        OP_SHRL   = 5'd9,
        OP_SHRA   = 5'd10,
        OP_ROTL   = 5'd11,
        OP_MUL8   = 5'd12,
        OP_MINU   = 5'd13,
        OP_MAXU   = 5'd14,
        OP_CMP3   = 5'd15,
        OP_BCLR   = 5'd16,
        OP_TOPBIT = 5'd17,
        OP_PUTBIT = 5'd18
    } alu_op_e;

    // Coded outcomes of the three-way compare
    localparam logic [7:0] CMP_CODE_GT = 8'h00;
    localparam logic [7:0] CMP_CODE_EQ = 8'h2B;
    localparam logic [7:0] CMP_CODE_LT = 8'h1E;

endpackage

// File: rtl/alu_arith_unit.sv
// Add/subtract with carry chaining, multiply, min/max and compare.
module alu_arith_unit
    import mcu_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   carry_q,
    output logic [W-1:0]   res,
    output logic [W-1:0]   carry_d,
    output logic           carry_we,
    output logic           hit
);
    localparam int MW = 8;
    localparam int PW = 2 * MW;

    logic [W:0]    sum_ext;
    logic [W:0]    dif_ext;
    logic [PW-1:0] prod;
    logic          a_lt_b;
    logic          a_eq_b;

    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b};
        dif_ext = {1'b0, a} - {1'b0, b};
        prod    = {{MW{1'b0}}, a[MW-1:0]} * {{MW{1'b0}}, b[MW-1:0]};
        a_lt_b  = a < b;
        a_eq_b  = a == b;
    end

    always_comb begin
        res      = '0;
        carry_d  = carry_q;
        carry_we = 1'b0;
        hit      = 1'b1;
        case (op)
            OP_ADD: begin
                res      = sum_ext[W-1:0];
                carry_d  = {{(W-1){1'b0}}, sum_ext[W]};
                carry_we = 1'b1;
            end
            OP_ADDHI: res = a + b + carry_q;
            OP_SUB: begin
                res      = dif_ext[W-1:0];
                carry_d  = {W{dif_ext[W]}};
                carry_we = 1'b1;
            end
            OP_SUBHI: res = a - b + carry_q;
            OP_MUL8:  res = {{(W-PW){1'b0}}, prod};
            OP_MINU:  res = a_lt_b ? a : b;
            OP_MAXU:  res = a_lt_b ? b : a;
            OP_CMP3: begin
                if (a_eq_b)      res = {{(W-8){1'b0}}, CMP_CODE_EQ};
                else if (a_lt_b) res = {{(W-8){1'b0}}, CMP_CODE_LT};
                else             res = {{(W-8){1'b0}}, CMP_CODE_GT};
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_bit_unit.sv
// Bitwise logic, shifts, rotate, bit-clear and packed single-bit write.
module alu_bit_unit
    import mcu_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           hit
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] amt;
    logic [SHW-1:0] put_idx;
    logic [W-1:0]   put_mask;
    logic [2*W-1:0] rot_dbl;

    always_comb begin
        amt      = b[SHW-1:0];
        put_idx  = b[SHW:1];
        put_mask = {{(W-1){1'b0}}, 1'b1} << put_idx;
        rot_dbl  = {a, a} << amt;
    end

    always_comb begin
        res = '0;
        hit = 1'b1;
        case (op)
            OP_AND:    res = a & b;
            OP_OR:     res = a | b;
            OP_XOR:    res = a ^ b;
            OP_NOT:    res = ~a;
            OP_BCLR:   res = a & ~b;
            OP_SHL:    res = a << amt;
            OP_SHRL:   res = a >> amt;
            OP_SHRA:   res = $unsigned($signed(a) >>> amt);
            OP_ROTL:   res = rot_dbl[2*W-1:W];
            OP_PUTBIT: res = (a & ~put_mask) | ({W{b[0]}} & put_mask);
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_scan_unit.sv
// Index of the highest set bit of the second operand.
module alu_scan_unit
    import mcu_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           hit
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] top_idx;

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) top_idx = SHW'(i);
        end
    end

    always_comb begin
        hit = (op == OP_TOPBIT);
        res = hit ? {{(W-SHW){1'b0}}, top_idx} : '0;
    end
endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
    import mcu_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op_i,
    input  logic [W-1:0]        a_i,
    input  logic [W-1:0]        b_i,
    output logic [W-1:0]        result_o,
    output logic [W-1:0]        carry_o,
    output logic                illegal_o
);
    alu_op_e      op;
    logic [W-1:0] carry_q;
    logic [W-1:0] carry_d;
    logic         carry_we;
    logic [W-1:0] res_ar, res_bt, res_sc;
    logic         hit_ar, hit_bt, hit_sc;

    assign op = alu_op_e'(op_i);

    alu_arith_unit #(.W(W)) u_arith (
        .op       (op),
        .a        (a_i),
        .b        (b_i),
        .carry_q  (carry_q),
        .res      (res_ar),
        .carry_d  (carry_d),
        .carry_we (carry_we),
        .hit      (hit_ar)
    );

    alu_bit_unit #(.W(W)) u_bit (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .res (res_bt),
        .hit (hit_bt)
    );

    alu_scan_unit #(.W(W)) u_scan (
        .op  (op),
        .b   (b_i),
        .res (res_sc),
        .hit (hit_sc)
    );

    // Carry register: the block's only state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        carry_q <= '0;
        else if (carry_we) carry_q <= carry_d;
    end

    // Output selection: units drive zero when not selected
    always_comb begin
        illegal_o = !(hit_ar || hit_bt || hit_sc);
        result_o  = res_ar | res_bt | res_sc;
        carry_o   = carry_q;
    end
endmodule

// File: rtl/mcu_alu_chk.sv
module mcu_alu_chk
    import mcu_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    a_i,
    input logic [W-1:0]    b_i,
    input logic [W-1:0]    result_o,
    input logic [W-1:0]    carry_o,
    input logic            illegal_o
);
    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_ADD |=> carry_o == ((($past(a_i) + $past(b_i)) < $past(a_i)) ? W'(1) : W'(0))); // R1

    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_SUB |=> carry_o == (($past(a_i) < $past(b_i)) ? {W{1'b1}} : W'(0))); // R3

    AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_ADD && op_i != OP_SUB) |=> $stable(carry_o)); // R13

    AST_CMP_EQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP3 && a_i == b_i) |-> result_o == W'(8'h2B)); // R9

    AST_CMP_LT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP3 && a_i < b_i) |-> result_o == W'(8'h1E)); // R9

    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_MINU |-> (result_o <= a_i && result_o <= b_i)); // R8

    AST_MUL8_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_MUL8 |-> result_o[W-1:16] == '0); // R7

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0 && op_i > OP_PUTBIT)); // R12

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> $stable(carry_o)); // R12
endmodule

bind mcu_alu mcu_alu_chk #(.W(W)) u_mcu_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .illegal_o (illegal_o)
);

// File: tb/tb_mcu_alu.sv
`timescale 1ns/1ps
module tb_mcu_alu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  op_i;
    logic [31:0] a_i, b_i;
    logic [31:0] result_o, carry_o;
    logic        illegal_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] model_carry = 32'h0;
    bit finished = 0;

    always #10 clk = ~clk;

    mcu_alu dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .result_o(result_o), .carry_o(carry_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] ref_result(input int op, input logic [31:0] a,
                                               input logic [31:0] b, input logic [31:0] c);
        logic [63:0] wide;
        logic [31:0] t;
        int k;
        case (op)
            0:  begin wide = 64'(a) + 64'(b); return wide[31:0]; end
            1:  return a + b + c;
            2:  begin wide = 64'(a) - 64'(b); return wide[31:0]; end
            3:  return a - b + c;
            4:  return a & b;
            5:  return a | b;
            6:  return a ^ b;
            7:  return ~a;
            8:  return a << b[4:0];
            9:  return a >> b[4:0];
            10: begin
                    t = a;
                    for (int i = 0; i < int'(b[4:0]); i++) t = {t[31], t[31:1]};
                    return t;
                end
            11: begin
                    t = a;
                    for (int i = 0; i < int'(b[4:0]); i++) t = {t[30:0], t[31]};
                    return t;
                end
            12: return 32'(int'(a[7:0]) * int'(b[7:0]));
            13: return (a < b) ? a : b;
            14: return (a > b) ? a : b;
            15: return (a > b) ? 32'h00 : ((a == b) ? 32'h2B : 32'h1E);
            16: return a & ~b;
            17: begin
                    k = 0;
                    for (int i = 31; i >= 0; i--) if (b[i] && k == 0) k = i;
                    return 32'(k);
                end
            18: begin
                    t = a;
                    t[b[5:1]] = b[0];
                    return t;
                end
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
            4, 5, 6, 7, 16: return "R5";
            8, 9, 10, 11: return "R6";
            12: return "R7";  13, 14: return "R8";  15: return "R9";
            17: return "R10"; 18: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // One operation: result checked mid-cycle, carry checked after the edge
    task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] wide;
        @(negedge clk);
        op_i = 5'(op); a_i = a; b_i = b;
        #1;
        check(req_of(op), "result", result_o, ref_result(op, a, b, model_carry));
        check(op > 18 ? "R12" : "R12", "illegal flag", 32'(illegal_o), (op > 18) ? 32'h1 : 32'h0);
        @(posedge clk);
        if (op == 0) begin
            wide = 64'(a) + 64'(b);
            model_carry = {31'h0, wide[32]};
        end else if (op == 2) begin
            model_carry = (a < b) ? 32'hFFFF_FFFF : 32'h0;
        end
        #1;
        check((op == 0) ? "R1" : (op == 2) ? "R3" : "R13", "carry", carry_o, model_carry);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb;
        int rop;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; op_i = 5'd0; a_i = 32'hFFFF_FFFF; b_i = 32'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R13", "carry in reset", carry_o, 32'h0);
        op_i = 5'd4;
        rst_n = 1'b1;

        // R1/R2: two-word add with carry out of the low word
        run_op(0, 32'hFFFF_FFFF, 32'h1);
        run_op(1, 32'd5, 32'd6);
        run_op(1, 32'd7, 32'd1);
        // R3/R4: two-word subtract with borrow
        run_op(2, 32'h0, 32'h1);
        run_op(3, 32'd5, 32'd2);
        run_op(2, 32'd9, 32'd9);
        run_op(3, 32'd5, 32'd2);
        run_op(0, 32'h8000_0000, 32'h8000_0000);
        run_op(4, 32'h1234, 32'h5678);     // R13: carry kept across logic op
        // R9 compare codes
        run_op(15, 32'd7, 32'd7);
        run_op(15, 32'd6, 32'd7);
        run_op(15, 32'hFFFF_FFFF, 32'd0);
        // R8 ties and unsigned ordering
        run_op(13, 32'h8000_0000, 32'h1);
        run_op(14, 32'h8000_0000, 32'h1);
        run_op(13, 32'd3, 32'd3);
        // R6 shift amount masking and sign fill
        run_op(10, 32'h8000_00F0, 32'h0000_0024);
        run_op(9,  32'h8000_00F0, 32'hFFFF_FFE4);
        run_op(8,  32'h0000_0001, 32'h0000_003F);
        run_op(11, 32'h8000_0001, 32'h0000_0021);
        run_op(11, 32'hDEAD_BEEF, 32'h0);
        // R7 multiply
        run_op(12, 32'hABCD_EFFF, 32'h1234_56FF);
        // R10 highest set bit
        run_op(17, 32'h0, 32'h0);
        run_op(17, 32'h0, 32'h1);
        run_op(17, 32'h0, 32'h8000_0000);
        run_op(17, 32'h0, 32'h0001_2345);
        // R11 packed bit write
        run_op(18, 32'h0, 32'h3F);
        run_op(18, 32'hFFFF_FFFF, 32'h3E);
        run_op(18, 32'h0, 32'h9);
        // R5 bit-clear and not
        run_op(16, 32'hFFFF_0000, 32'hF0F0_F0F0);
        run_op(7, 32'h0F0F_0000, 32'h0);
        // R12 illegal codes after a carry is set
        run_op(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(19, 32'h1, 32'h2);
        run_op(31, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        for (int n = 0; n < 1500; n++) begin
            rop = int'($urandom % 32);
            ra = $urandom;
            case ($urandom % 4)
                0: rb = ra;
                1: rb = {ra[31:8], 8'($urandom)};
                2: rb = $urandom % 64;
                default: rb = $urandom;
            endcase
            run_op(rop, ra, rb);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule